// File: doc/BRIEF.md
# Constant Buffer Streaming Uploader

The uploader collects 32-bit words that a command stream writes to a group of sixteen data methods and sends them to memory as one block write. Three setup methods load the destination base address, the buffer size limit and a running byte position. The first word sent to a data method opens an upload and notes the current byte position as its start offset. Each word is kept in a staging memory and moves the position forward by four bytes. A burst is a series of back-to-back method beats that carry the same method number.

The upload is committed only when it has to be. This happens when a beat names any other method, when it names a different data method, or when the staging memory is full. The triggering beat is stalled with `mth_ready` low while the block plays the staged words out on a valid/ready memory port, one word per cycle. The request carries the address (base plus start offset) and the byte length (position minus start offset). A one-cycle `done` pulse follows the last word. A commit with a zero base address, or with the position past the size limit, sends no words and raises a one-cycle `err` pulse instead. After a commit, whether good or rejected, no data method is active and the stalled beat is accepted.

Top module: `cbuf_stream_uploader`

## Requirements
- R1: After reset, `wr_valid`, `done` and `err` are low and `mth_ready` is high.
- R2: The first word to a data method (method numbers DATA_FIRST to DATA_FIRST+15, port = method minus DATA_FIRST) records the current position as the start offset, and the commit address is base (method M_BASE) plus that offset.
- R3: Each accepted data word advances the byte position (method M_POS) by 4, and the commit length `wr_len` equals 4 times the number of words staged.
- R4: Staged words leave on `wr_data` in the order they arrived, one per cycle where `wr_valid` and `wr_ready` are both high.
- R5: While an upload is open, a beat naming a method that is not a data method is held off (`mth_ready` low) until the commit has finished, and it is then accepted.
- R6: A beat to a different data method commits the open upload and then opens a new one whose start offset is the old upload's end position.
- R7: A commit with a base address of zero sends no words and pulses `err` for one cycle.
- R8: A commit whose position is greater than the size limit (method M_SIZE) sends no words and pulses `err`.
- R9: When DEPTH words are staged, a further word to the same data method first commits those DEPTH words and then opens a new upload.
- R10: `wr_last` is high on the final word only, and `done` pulses for exactly one cycle, in the cycle after the final word is taken.
- R11: A beat naming a method that is neither a data method nor a setup method, sent while no upload is open, starts no memory write.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_len` and `wr_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mth_valid | input | 1 | Method beat present |
| mth_ready | output | 1 | Method beat accepted this cycle |
| mth_addr | input | MW | Method number |
| mth_data | input | DW | Method argument word |
| wr_valid | output | 1 | Memory write word valid |
| wr_ready | input | 1 | Memory takes the word |
| wr_addr | output | AW | Byte address of the block write |
| wr_len | output | LW | Byte length of the block write |
| wr_data | output | DW | Current data word |
| wr_last | output | 1 | Final word of the block write |
| done | output | 1 | One-cycle pulse after a completed block write |
| err | output | 1 | One-cycle pulse for a rejected commit |

## Verification
The hardest situation to reach is the staging memory filling up. Reaching it takes DEPTH back-to-back words to one data method followed by one more. The bench streams 257 numbered words into a single port and expects two block writes: a first of 1024 bytes, held off until the 257th beat, and then a 4-byte write. It checks every word across both writes. A second hard situation is a port switch in the middle of a burst with the memory side stalling in a repeating pattern. The bench forces it by lowering `wr_ready` two cycles in every three while it checks addresses and order.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } cbu_state_e;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode #(
    parameter int          MW         = 12,
    parameter int          NUM_PORTS  = 16,
    parameter logic [11:0] DATA_FIRST = 12'h100,
    parameter logic [11:0] M_BASE     = 12'h0F0,
    parameter logic [11:0] M_SIZE     = 12'h0F1,
    parameter logic [11:0] M_POS      = 12'h0F2,
    localparam int         PW         = $clog2(NUM_PORTS)
) (
    input  logic [MW-1:0] addr,
    output logic          is_data,
    output logic [PW-1:0] port,
    output logic          is_base,
    output logic          is_size,
    output logic          is_pos
);
    logic [NUM_PORTS-1:0] hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign hit[p] = (addr == MW'(DATA_FIRST + 12'(p)));
    end

    always_comb begin
        port = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p]) port = PW'(p);
        end
    end

    assign is_data = |hit;
    assign is_base = (addr == MW'(M_BASE));
    assign is_size = (addr == MW'(M_SIZE));
    assign is_pos  = (addr == MW'(M_POS));
endmodule

// File: rtl/cbu_stage_ram.sv
module cbu_stage_ram #(
    parameter int  DW    = 32,
    parameter int  DEPTH = 256,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cbuf_stream_uploader.sv
module cbuf_stream_uploader
    import cbu_pkg::*;
#(
    parameter int          MW         = 12,
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          DEPTH      = 256,
    parameter int          NUM_PORTS  = 16,
    parameter logic [11:0] DATA_FIRST = 12'h100,
    parameter logic [11:0] M_BASE     = 12'h0F0,
    parameter logic [11:0] M_SIZE     = 12'h0F1,
    parameter logic [11:0] M_POS      = 12'h0F2,
    localparam int         LW         = $clog2(DEPTH * 4) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mth_valid,
    output logic          mth_ready,
    input  logic [MW-1:0] mth_addr,
    input  logic [DW-1:0] mth_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [LW-1:0] wr_len,
    output logic [DW-1:0] wr_data,
    output logic          wr_last,
    output logic          done,
    output logic          err
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;
    localparam int PW = $clog2(NUM_PORTS);

    typedef struct packed {
        cbu_state_e    st;
        logic [PW-1:0] port;
        logic [CW-1:0] cnt;
        logic [AW-1:0] start;
        logic [AW-1:0] pos;
        logic [AW-1:0] base;
        logic [AW-1:0] size;
        logic [IW-1:0] rd;
        logic [AW-1:0] waddr;
        logic [LW-1:0] wlen;
        logic          done;
        logic          err;
    } cbu_regs_t;

    cbu_regs_t r_d, r_q;

    logic          dec_data, dec_base, dec_size, dec_pos;
    logic [PW-1:0] dec_port;
    logic          ram_we;
    logic [IW-1:0] ram_wa;
    logic [DW-1:0] ram_rd;
    logic          ready_d;
    logic          is_final;

    cbu_decode #(
        .MW(MW), .NUM_PORTS(NUM_PORTS), .DATA_FIRST(DATA_FIRST),
        .M_BASE(M_BASE), .M_SIZE(M_SIZE), .M_POS(M_POS)
    ) u_dec (
        .addr(mth_addr), .is_data(dec_data), .port(dec_port),
        .is_base(dec_base), .is_size(dec_size), .is_pos(dec_pos)
    );

    cbu_stage_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(mth_data),
        .raddr(r_q.rd), .rdata(ram_rd)
    );

    // final staged word of the block being drained
    assign is_final = (r_q.rd == IW'(r_q.cnt - CW'(1)));

    always_comb begin
        logic need_commit;
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        ram_we      = 1'b0;
        ram_wa      = '0;
        ready_d     = 1'b0;
        need_commit = 1'b0;

        if (r_q.st == ST_DRAIN) begin
            if (wr_ready) begin
                if (is_final) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.rd   = '0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.rd = r_q.rd + IW'(1);
                end
            end
        end else begin
            need_commit = (r_q.st == ST_FILL) && mth_valid &&
                          (!dec_data || (dec_port != r_q.port) ||
                           (r_q.cnt == CW'(DEPTH)));
            if (need_commit) begin
                r_d.waddr = r_q.base + r_q.start;
                r_d.wlen  = LW'(r_q.pos - r_q.start);
                if ((r_q.base == '0) || (r_q.pos > r_q.size)) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.st = ST_DRAIN;
                    r_d.rd = '0;
                end
            end else begin
                ready_d = 1'b1;
                if (mth_valid) begin
                    if (dec_data) begin
                        ram_we = 1'b1;
                        if (r_q.st == ST_IDLE) begin
                            r_d.start = r_q.pos;
                            r_d.port  = dec_port;
                            r_d.st    = ST_FILL;
                            ram_wa    = '0;
                            r_d.cnt   = CW'(1);
                        end else begin
                            ram_wa  = r_q.cnt[IW-1:0];
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                        r_d.pos = r_q.pos + AW'(4);
                    end else if (dec_base) begin
                        r_d.base = AW'(mth_data);
                    end else if (dec_size) begin
                        r_d.size = AW'(mth_data);
                    end else if (dec_pos) begin
                        r_d.pos = AW'(mth_data);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mth_ready = ready_d;
    assign wr_valid  = (r_q.st == ST_DRAIN);
    assign wr_addr   = r_q.waddr;
    assign wr_len    = r_q.wlen;
    assign wr_data   = ram_rd;
    assign wr_last   = wr_valid && is_final;
    assign done      = r_q.done;
    assign err       = r_q.err;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mth_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [LW-1:0] wr_len,
    input logic [DW-1:0] wr_data,
    input logic          wr_last,
    input logic          done,
    input logic          err
);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                     $stable(wr_len) && $stable(wr_data)));

    assert_stall_during_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !mth_ready);

    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_last) |=> done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_needs_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready && wr_last));

    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_valid && !done));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind cbuf_stream_uploader cbu_checker #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mth_ready(mth_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_last(wr_last), .done(done), .err(err)
);

// File: tb/cbuf_stream_uploader_bench.sv
module cbuf_stream_uploader_bench;
    localparam logic [11:0] DF   = 12'h100;
    localparam logic [11:0] MB   = 12'h0F0;
    localparam logic [11:0] MS   = 12'h0F1;
    localparam logic [11:0] MP   = 12'h0F2;
    localparam logic [11:0] NOP  = 12'h050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mv = 1'b0;
    logic        mth_ready;
    logic [11:0] ma = '0;
    logic [31:0] md = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [10:0] wr_len;
    logic [31:0] wr_data;
    logic        wr_last;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int stall_mode = 0;
    int cyc = 0;

    logic [31:0] cap [512];
    int          cap_n = 0;
    logic [31:0] com_addr [8];
    int          com_len [8];
    int          com_n = 0;
    int          done_n = 0;
    int          err_n = 0;
    int          last_bad = 0;
    bit          first_beat = 1;

    always #2.5 clk = ~clk;

    cbuf_stream_uploader u_cbuf_stream_uploader (
        .clk(clk), .rst_n(rst_n), .mth_valid(mv), .mth_ready(mth_ready),
        .mth_addr(ma), .mth_data(md), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data), .wr_last(wr_last),
        .done(done), .err(err)
    );

    // memory side: drive ready at the falling edge, record what the next rising edge takes
    always begin
        @(negedge clk);
        cyc++;
        wr_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        #1;
        if (done) done_n++;
        if (err) err_n++;
        if (wr_valid && wr_ready) begin
            if (first_beat && com_n < 8) begin
                com_addr[com_n] = wr_addr;
                com_len[com_n]  = int'(wr_len);
            end
            first_beat = 0;
            if (cap_n < 512) cap[cap_n] = wr_data;
            cap_n++;
            if (wr_last) begin
                com_n++;
                first_beat = 1;
            end
        end else if (wr_valid === 1'b0 && wr_last !== 1'b0) begin
            last_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        cap_n = 0; com_n = 0; done_n = 0; err_n = 0; first_beat = 1;
    endtask

    task automatic send(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        mv = 1'b1; ma = a; md = d;
        #1;
        while (!mth_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 mv = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #2;
    endtask

    task automatic setup(input logic [31:0] b, input logic [31:0] s, input logic [31:0] p);
        send(MB, b); send(MS, s); send(MP, p);
    endtask

    task automatic t_reset();
        @(negedge clk); #2;
        check(wr_valid == 1'b0, "R1 wr_valid", int'(wr_valid), 0);
        check(mth_ready == 1'b1, "R1 mth_ready", int'(mth_ready), 1);
        check(done == 1'b0 && err == 1'b0, "R1 done/err", int'({done, err}), 0);
    endtask

    task automatic t_basic();
        clear_log();
        setup(32'h1000, 32'h400, 32'h10);
        send(DF + 12'd5, 32'hA0);
        send(DF + 12'd5, 32'hA1);
        send(DF + 12'd5, 32'hA2);
        settle();
        check(com_n == 0, "R5 no write before trigger", com_n, 0);
        send(NOP, 32'h0);
        settle();
        check(com_n == 1, "R5 one commit", com_n, 1);
        check(com_addr[0] == 32'h1010, "R2 address", int'(com_addr[0]), 32'h1010);
        check(com_len[0] == 12, "R3 length", com_len[0], 12);
        check(cap_n == 3 && cap[0] == 32'hA0 && cap[1] == 32'hA1 && cap[2] == 32'hA2,
              "R4 order", int'(cap[2]), 32'hA2);
        check(done_n == 1, "R10 done pulse", done_n, 1);
        check(last_bad == 0, "R10 wr_last only with data", last_bad, 0);
    endtask

    task automatic t_switch();
        clear_log();
        stall_mode = 1;
        setup(32'h1000, 32'h1000, 32'h40);
        send(DF + 12'd2, 32'hB0);
        send(DF + 12'd2, 32'hB1);
        send(DF + 12'd3, 32'hC0);
        send(DF + 12'd3, 32'hC1);
        send(DF + 12'd3, 32'hC2);
        send(NOP, 32'h0);
        settle();
        stall_mode = 0;
        check(com_n == 2, "R6 two commits", com_n, 2);
        check(com_addr[0] == 32'h1040 && com_len[0] == 8, "R6 first upload",
              int'(com_addr[0]), 32'h1040);
        check(com_addr[1] == 32'h1048, "R6 second start", int'(com_addr[1]), 32'h1048);
        check(com_len[1] == 12, "R3 second length", com_len[1], 12);
        check(cap_n == 5 && cap[0] == 32'hB0 && cap[2] == 32'hC0 && cap[4] == 32'hC2,
              "R4 order with stalls", int'(cap[4]), 32'hC2);
        check(done_n == 2, "R10 done count", done_n, 2);
    endtask

    task automatic t_full();
        clear_log();
        setup(32'h2000, 32'h10000, 32'h0);
        for (int i = 0; i < 257; i++) send(DF + 12'd7, 32'(i));
        settle();
        check(com_n == 1 && com_len[0] == 1024, "R9 commit at full",
              com_len[0], 1024);
        check(com_addr[0] == 32'h2000, "R9 address", int'(com_addr[0]), 32'h2000);
        send(NOP, 32'h0);
        settle();
        check(com_n == 2 && com_addr[1] == 32'h2400 && com_len[1] == 4,
              "R9 new upload", int'(com_addr[1]), 32'h2400);
        begin
            int wrong = 0;
            for (int i = 0; i < 257; i++) if (cap[i] != 32'(i)) wrong++;
            check(cap_n == 257 && wrong == 0, "R9 data", wrong, 0);
        end
    endtask

    task automatic t_base_zero();
        clear_log();
        setup(32'h0, 32'h400, 32'h0);
        send(DF, 32'h11);
        send(DF, 32'h12);
        send(NOP, 32'h0);
        settle();
        check(err_n == 1, "R7 err pulse", err_n, 1);
        check(cap_n == 0 && done_n == 0, "R7 no words", cap_n, 0);
    endtask

    task automatic t_oversize();
        clear_log();
        setup(32'h3000, 32'h8, 32'h0);
        send(DF + 12'd15, 32'h21);
        send(DF + 12'd15, 32'h22);
        send(DF + 12'd15, 32'h23);
        send(NOP, 32'h0);
        settle();
        check(err_n == 1, "R8 err pulse", err_n, 1);
        check(cap_n == 0, "R8 no words", cap_n, 0);
        // still accepted afterwards: an in-limit upload works
        clear_log();
        send(MP, 32'h0);
        send(DF + 12'd15, 32'h31);
        send(NOP, 32'h0);
        settle();
        check(com_n == 1 && com_addr[0] == 32'h3000 && cap[0] == 32'h31,
              "R8 recovery", int'(cap[0]), 32'h31);
    endtask

    task automatic t_idle_nop();
        clear_log();
        send(NOP, 32'hDEAD);
        send(NOP + 12'd1, 32'hBEEF);
        settle();
        check(cap_n == 0 && done_n == 0 && err_n == 0, "R11 idle method ignored",
              cap_n, 0);
        check(mth_ready == 1'b1, "R11 ready stays", int'(mth_ready), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_switch();
        t_full();
        t_base_zero();
        t_oversize();
        t_idle_nop();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule